// File: doc/BRIEF.md
# Upstream Read Request Pacer

The pacer sits between a set of downstream requester ports and a single upstream request queue. Each port offers non-posted read requests (a tag and a byte length) through a valid/ready handshake. The block holds them in a short per-port queue and forwards them one at a time to the upstream output. For each port it tracks how many forwarded reads are still outstanding. A port whose outstanding count has reached its programmed cap is held back, so that one requester with many large reads cannot fill the upstream queue ahead of everyone else.

While a port is held, the other ports keep forwarding. A port with one small read therefore gets it out right behind a single read from the heavy port, rather than behind the whole backlog. Pacing only changes the order among ports and never discards anything. Each completion report names a port and frees one unit of that port's credit. A cap of zero turns pacing off for that port. A configuration write port sets the caps.

Top module: `pacer_top`

## Requirements
- R1: After reset `upValid` is 0, every `reqReady` bit is 1, `errSticky` is 0, and every port's cap is `DEF_LIMIT` (default 0, unpaced).
- R2: Every forwarded request adds one to its port's outstanding count. A port with a nonzero cap L forwards nothing more once its count equals L, even while `upReady` is 1.
- R3: While one port is held at its cap, requests queued on other eligible ports are forwarded on the following cycles without waiting for the held port.
- R4: A cycle with `cplValid` high lowers the count of port `cplPort` by one when that count is nonzero, which lets a held port forward again.
- R5: Among eligible ports (a queued request and not at cap), the grant goes in round-robin order starting after the last port granted. Port 0 is first after reset.
- R6: A cap value of 0 means the port is never held, whatever its count.
- R7: Each port forwards its requests in arrival order from a queue of `DEPTH` (4) entries. `reqReady` for a port is 0 exactly when its queue is full, and a request offered while `reqReady` is 0 is not taken.
- R8: Outstanding counts saturate at 2^`CNT_W`-1 and never wrap.
- R9: A completion for a port whose count is 0 leaves the count at 0 and sets `errSticky`, which stays 1 until reset.
- R10: No accepted request is lost. Once enough completions return, every accepted request is forwarded exactly once.
- R11: A request leaves when `upValid` and `upReady` are both 1 at a rising edge. `upPort`, `upTag` and `upLen` carry the granted port's oldest request, and `upValid` stays 1 while `upReady` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Per-port request offer |
| reqReady | output | NUM_PORTS | Per-port queue has room |
| reqTag | input | NUM_PORTS*TAG_W | Per-port request tags, port i at bits [i*TAG_W +: TAG_W] |
| reqLen | input | NUM_PORTS*LEN_W | Per-port byte lengths, port i at bits [i*LEN_W +: LEN_W] |
| cfgWrEn | input | 1 | Write strobe for a port cap |
| cfgWrPort | input | PW | Port whose cap is written |
| cfgWrLimit | input | CNT_W | New cap value (0 = unpaced) |
| cplValid | input | 1 | A forwarded read has fully completed |
| cplPort | input | PW | Port that owned the completed read |
| upValid | output | 1 | Upstream request available |
| upReady | input | 1 | Upstream queue accepts a request |
| upPort | output | PW | Source port of the upstream request |
| upTag | output | TAG_W | Tag of the upstream request |
| upLen | output | LEN_W | Byte length of the upstream request |
| errSticky | output | 1 | Completion arrived for a port with nothing outstanding |

## Verification
The bench uses the defaults: four ports, a four-entry queue per port, 4-bit counts, 13-bit lengths and 5-bit tags. With a four-entry queue, one port fills in four pushes, and a backlog of 4 KB reads shows the held-port pattern within a few cycles. With 4-bit counts, saturation at 15 can be reached with twenty forwarded requests. Four ports leave room for a heavy port, a light port and a three-way round-robin rotation in the same run.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  // Widest port index the strobe struct can carry (up to 8 ports).
  localparam int PORT_IDX_W = 3;

  typedef struct packed {
    logic                  fire;      // a request leaves this cycle
    logic [PORT_IDX_W-1:0] grantIdx;  // port currently selected
  } pacer_strobe_t;
endpackage

// File: rtl/pacer_fifo.sv
module pacer_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         notEmpty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   fill;
  logic doPush, doPop;

  assign full     = (fill == (AW+1)'(DEPTH));
  assign notEmpty = (fill != '0);
  assign doPush   = push && !full;
  assign doPop    = pop && notEmpty;
  assign dout     = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= din;
        wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      end
      if (doPop) rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop) fill <= fill + 1'b1;
      else if (doPop && !doPush) fill <= fill - 1'b1;
    end
  end
endmodule

// File: rtl/pacer_datapath.sv
module pacer_datapath
  import pacer_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TAG_W     = 5,
  parameter int LEN_W     = 13,
  parameter int CNT_W     = 4,
  parameter int DEPTH     = 4,
  parameter int DEF_LIMIT = 0,
  localparam int PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int EW       = TAG_W + LEN_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS-1:0]       reqValid,
  output logic [NUM_PORTS-1:0]       reqReady,
  input  logic [NUM_PORTS*TAG_W-1:0] reqTag,
  input  logic [NUM_PORTS*LEN_W-1:0] reqLen,
  input  logic                       cfgWrEn,
  input  logic [PW-1:0]              cfgWrPort,
  input  logic [CNT_W-1:0]           cfgWrLimit,
  input  logic                       cplValid,
  input  logic [PW-1:0]              cplPort,
  input  pacer_strobe_t              strobe,
  output logic [NUM_PORTS-1:0]       headValid,
  output logic [NUM_PORTS-1:0]       atCap,
  output logic [TAG_W-1:0]           upTag,
  output logic [LEN_W-1:0]           upLen,
  output logic                       errSticky
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_PORTS-1:0][EW-1:0]    headData;
  logic [NUM_PORTS-1:0][CNT_W-1:0] cntVec;
  logic [NUM_PORTS-1:0]            cntZero;
  logic                            zeroHit;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic             full, pushI, popI, incHit, decHit;
    logic [EW-1:0]    dout;
    logic [CNT_W-1:0] cntQ, limitQ;

    assign pushI  = reqValid[i] && !full;
    assign popI   = strobe.fire && (strobe.grantIdx == PORT_IDX_W'(i));
    assign incHit = popI;
    assign decHit = cplValid && (cplPort == PW'(i)) && (cntQ != '0);

    pacer_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .push     (pushI),
      .din      ({reqTag[i*TAG_W +: TAG_W], reqLen[i*LEN_W +: LEN_W]}),
      .pop      (popI),
      .dout     (dout),
      .full     (full),
      .notEmpty (headValid[i])
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ   <= '0;
        limitQ <= CNT_W'(DEF_LIMIT);
      end else begin
        if (incHit && !decHit)      cntQ <= (cntQ == CNT_MAX) ? cntQ : cntQ + 1'b1;
        else if (decHit && !incHit) cntQ <= cntQ - 1'b1;
        if (cfgWrEn && (cfgWrPort == PW'(i))) limitQ <= cfgWrLimit;
      end
    end

    assign reqReady[i] = !full;
    assign headData[i] = dout;
    assign cntVec[i]   = cntQ;
    assign cntZero[i]  = (cntQ == '0);
    assign atCap[i]    = (limitQ != '0) && (cntQ >= limitQ);
  end

  always_comb begin
    upTag   = '0;
    upLen   = '0;
    zeroHit = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (strobe.grantIdx == PORT_IDX_W'(i)) {upTag, upLen} = headData[i];
      if (cplPort == PW'(i)) zeroHit = cntZero[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errSticky <= 1'b0;
    else if (cplValid && zeroHit) errSticky <= 1'b1;
  end
endmodule

// File: rtl/pacer_ctrl.sv
module pacer_ctrl
  import pacer_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] headValid,
  input  logic [NUM_PORTS-1:0] atCap,
  input  logic                 upReady,
  output pacer_strobe_t        strobe,
  output logic                 upValid
);
  logic [NUM_PORTS-1:0]  elig;
  logic [PORT_IDX_W-1:0] lastGrant, pick;
  logic                  found;

  assign elig = headValid & ~atCap;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_PORTS; k++) begin
      if (!found && elig[(int'(lastGrant) + k) % NUM_PORTS]) begin
        found = 1'b1;
        pick  = PORT_IDX_W'((int'(lastGrant) + k) % NUM_PORTS);
      end
    end
  end

  assign upValid         = found;
  assign strobe.fire     = found && upReady;
  assign strobe.grantIdx = pick;

  always_ff @(posedge clk) begin
    if (!rstN) lastGrant <= PORT_IDX_W'(NUM_PORTS - 1);
    else if (strobe.fire) lastGrant <= pick;
  end
endmodule

// File: rtl/pacer_top.sv
module pacer_top
  import pacer_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int TAG_W     = 5,
  parameter int LEN_W     = 13,
  parameter int CNT_W     = 4,
  parameter int DEPTH     = 4,
  parameter int DEF_LIMIT = 0,
  localparam int PW       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS-1:0]       reqValid,
  output logic [NUM_PORTS-1:0]       reqReady,
  input  logic [NUM_PORTS*TAG_W-1:0] reqTag,
  input  logic [NUM_PORTS*LEN_W-1:0] reqLen,
  input  logic                       cfgWrEn,
  input  logic [PW-1:0]              cfgWrPort,
  input  logic [CNT_W-1:0]           cfgWrLimit,
  input  logic                       cplValid,
  input  logic [PW-1:0]              cplPort,
  output logic                       upValid,
  input  logic                       upReady,
  output logic [PW-1:0]              upPort,
  output logic [TAG_W-1:0]           upTag,
  output logic [LEN_W-1:0]           upLen,
  output logic                       errSticky
);
  pacer_strobe_t        strobe;
  logic [NUM_PORTS-1:0] headValid, atCap;

  pacer_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .headValid (headValid),
    .atCap     (atCap),
    .upReady   (upReady),
    .strobe    (strobe),
    .upValid   (upValid)
  );

  pacer_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .TAG_W     (TAG_W),
    .LEN_W     (LEN_W),
    .CNT_W     (CNT_W),
    .DEPTH     (DEPTH),
    .DEF_LIMIT (DEF_LIMIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .reqTag     (reqTag),
    .reqLen     (reqLen),
    .cfgWrEn    (cfgWrEn),
    .cfgWrPort  (cfgWrPort),
    .cfgWrLimit (cfgWrLimit),
    .cplValid   (cplValid),
    .cplPort    (cplPort),
    .strobe     (strobe),
    .headValid  (headValid),
    .atCap      (atCap),
    .upTag      (upTag),
    .upLen      (upLen),
    .errSticky  (errSticky)
  );

  assign upPort = strobe.grantIdx[PW-1:0];
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker #(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 4,
  parameter int DEPTH     = 4,
  parameter int PW        = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] reqValid,
  input logic [NUM_PORTS-1:0] reqReady,
  input logic                 cfgWrEn,
  input logic [PW-1:0]        cfgWrPort,
  input logic [CNT_W-1:0]     cfgWrLimit,
  input logic                 cplValid,
  input logic [PW-1:0]        cplPort,
  input logic                 upValid,
  input logic                 upReady,
  input logic [PW-1:0]        upPort,
  input logic                 errSticky
);
  logic [NUM_PORTS-1:0] shadowZero;
  logic                 cplOnZero;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_shadow
    logic [CNT_W-1:0] cntQ, limQ;
    logic [7:0]       occQ;
    logic             fireI, cplI, pushI;

    assign fireI = upValid && upReady && (upPort == PW'(i));
    assign cplI  = cplValid && (cplPort == PW'(i)) && (cntQ != '0);
    assign pushI = reqValid[i] && reqReady[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
        limQ <= '0;
        occQ <= '0;
      end else begin
        if (fireI && !cplI)      cntQ <= (&cntQ) ? cntQ : cntQ + 1'b1;
        else if (cplI && !fireI) cntQ <= cntQ - 1'b1;
        if (cfgWrEn && (cfgWrPort == PW'(i))) limQ <= cfgWrLimit;
        if (pushI && !fireI)      occQ <= occQ + 1'b1;
        else if (fireI && !pushI) occQ <= occQ - 1'b1;
      end
    end

    assign shadowZero[i] = (cntQ == '0);

    // R2: a paced port never forwards at or above its cap
    p_cap_respected_r2: assert property (@(posedge clk) disable iff (!rstN)
      (fireI && limQ != '0) |-> (cntQ < limQ));

    // R7: ready drops only when the queue is full
    p_ready_full_r7: assert property (@(posedge clk) disable iff (!rstN)
      !reqReady[i] |-> (occQ == 8'(DEPTH)));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
      occQ <= 8'(DEPTH));
  end

  always_comb begin
    cplOnZero = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (cplPort == PW'(i)) cplOnZero = shadowZero[i];
  end

  // R9: the error flag sets on a stray completion and then holds
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cplValid && cplOnZero) |=> errSticky);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  // R11: an offered request is not withdrawn while upstream stalls
  p_hold_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !upReady && !cfgWrEn) |=> upValid);
endmodule

bind pacer_top pacer_checker #(
  .NUM_PORTS (NUM_PORTS),
  .CNT_W     (CNT_W),
  .DEPTH     (DEPTH),
  .PW        (PW)
) u_pacer_checker (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .cfgWrEn    (cfgWrEn),
  .cfgWrPort  (cfgWrPort),
  .cfgWrLimit (cfgWrLimit),
  .cplValid   (cplValid),
  .cplPort    (cplPort),
  .upValid    (upValid),
  .upReady    (upReady),
  .upPort     (upPort),
  .errSticky  (errSticky)
);

// File: tb/pacer_top_bench.sv
`timescale 1ns/1ps
module pacer_top_bench;
  localparam int NP = 4, TW = 5, LW = 13, CW = 4, PWB = 2;

  logic clk = 1'b0;
  logic rstN;
  logic [NP-1:0]    reqValid;
  logic [NP-1:0]    reqReady;
  logic [NP*TW-1:0] reqTag;
  logic [NP*LW-1:0] reqLen;
  logic             cfgWrEn;
  logic [PWB-1:0]   cfgWrPort;
  logic [CW-1:0]    cfgWrLimit;
  logic             cplValid;
  logic [PWB-1:0]   cplPort;
  logic             upValid, upReady;
  logic [PWB-1:0]   upPort;
  logic [TW-1:0]    upTag;
  logic [LW-1:0]    upLen;
  logic             errSticky;

  always #2.5 clk = ~clk;

  pacer_top u_pacer_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqTag(reqTag), .reqLen(reqLen), .cfgWrEn(cfgWrEn), .cfgWrPort(cfgWrPort),
    .cfgWrLimit(cfgWrLimit), .cplValid(cplValid), .cplPort(cplPort),
    .upValid(upValid), .upReady(upReady), .upPort(upPort), .upTag(upTag),
    .upLen(upLen), .errSticky(errSticky)
  );

  int checks = 0, fails = 0;
  int logPort [64];
  int logTag  [64];
  int logLen  [64];
  int logCount = 0;
  bit done = 0;

  // {port, cap, requests pushed, requests expected to leave}
  localparam int VEC [5][4] = '{
    '{0, 1, 4, 1}, '{1, 2, 3, 2}, '{2, 0, 4, 4}, '{3, 3, 2, 2}, '{1, 4, 4, 4}
  };

  always @(negedge clk) begin
    if (rstN && upValid && upReady && logCount < 64) begin
      logPort[logCount] = int'(upPort);
      logTag[logCount]  = int'(upTag);
      logLen[logCount]  = int'(upLen);
      logCount = logCount + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rstN = 1'b0; reqValid = '0; reqTag = '0; reqLen = '0;
    cfgWrEn = 1'b0; cfgWrPort = '0; cfgWrLimit = '0;
    cplValid = 1'b0; cplPort = '0; upReady = 1'b0;
    tick(2);
    rstN = 1'b1;
    logCount = 0;
    tick(1);
  endtask

  task automatic setLimit(input int p, input int l);
    cfgWrEn = 1'b1; cfgWrPort = PWB'(p); cfgWrLimit = CW'(l);
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic pushReq(input int p, input int tag, input int len);
    reqValid[p] = 1'b1;
    reqTag[p*TW +: TW] = TW'(tag);
    reqLen[p*LW +: LW] = LW'(len);
    tick(1);
    reqValid[p] = 1'b0;
  endtask

  task automatic sendCpl(input int p);
    cplValid = 1'b1; cplPort = PWB'(p);
    tick(1);
    cplValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    doReset();
    // R1: state after reset
    check("R1 upValid", int'(upValid), 0);
    check("R1 reqReady", int'(reqReady), 15);
    check("R1 errSticky", int'(errSticky), 0);

    // Table walk: single port, cap versus backlog (R2 and R6)
    for (int v = 0; v < 5; v++) begin
      doReset();
      setLimit(VEC[v][0], VEC[v][1]);
      upReady = 1'b1;
      for (int r = 0; r < VEC[v][2]; r++) pushReq(VEC[v][0], r, 512);
      tick(6);
      check((VEC[v][1] == 0) ? "R6 unpaced forwarded" : "R2 capped forwarded",
            logCount, VEC[v][3]);
      check("R2 held with upReady high", int'(upValid), 0);
    end

    // Heavy port held, light port goes through (R3, R4, R7, R11)
    doReset();
    setLimit(0, 1);
    for (int r = 0; r < 4; r++) pushReq(0, r, 2048);
    pushReq(1, 8, 1024);
    pushReq(1, 9, 1024);
    check("R11 valid while stalled", int'(upValid), 1);
    upReady = 1'b1;
    tick(8);
    check("R3 forwarded count", logCount, 3);
    check("R3 first is heavy", logPort[0] * 100 + logTag[0], 0);
    check("R11 first len", logLen[0], 2048);
    check("R3 second light", logPort[1] * 100 + logTag[1], 108);
    check("R3 third light", logPort[2] * 100 + logTag[2], 109);
    check("R11 light len", logLen[2], 1024);
    sendCpl(0);
    tick(4);
    check("R4 released one", logCount, 4);
    check("R7 order in port", logTag[3], 1);

    // Sixteen-read backlog scenario scaled to the queue (R3, R10)
    doReset();
    setLimit(2, 2);
    upReady = 1'b1;
    for (int r = 0; r < 4; r++) pushReq(2, r, 4096);
    pushReq(3, 20, 1024);
    tick(4);
    check("R3 light after two heavy", logCount * 10 + logPort[2], 33);
    sendCpl(2);
    sendCpl(2);
    tick(4);
    check("R10 all delivered", logCount, 5);
    check("R10 last tag", logPort[4] * 100 + logTag[4], 203);

    // Round-robin rotation (R5)
    doReset();
    pushReq(2, 1, 64);
    pushReq(0, 2, 64);
    pushReq(1, 3, 64);
    upReady = 1'b1;
    tick(5);
    check("R5 rotation", logPort[0] * 100 + logPort[1] * 10 + logPort[2], 12);
    upReady = 1'b0;
    pushReq(1, 4, 64);
    pushReq(3, 5, 64);
    upReady = 1'b1;
    tick(4);
    check("R5 after last grant", logPort[3] * 10 + logPort[4], 31);

    // Queue full (R7)
    doReset();
    for (int r = 0; r < 4; r++) pushReq(1, r, 128);
    check("R7 full ready low", int'(reqReady[1]), 0);
    check("R7 other ready", int'(reqReady[0]), 1);
    pushReq(1, 31, 128);
    upReady = 1'b1;
    tick(8);
    check("R7 extra dropped", logCount, 4);
    check("R7 fifo order", logTag[0] * 1000 + logTag[1] * 100 + logTag[2] * 10 + logTag[3], 123);

    // Stray completion (R9)
    doReset();
    setLimit(0, 1);
    sendCpl(0);
    check("R9 error set", int'(errSticky), 1);
    upReady = 1'b1;
    pushReq(0, 6, 256);
    pushReq(0, 7, 256);
    tick(4);
    check("R9 count stayed zero", logCount, 1);
    check("R9 still sticky", int'(errSticky), 1);
    doReset();
    check("R1 reset clears error", int'(errSticky), 0);

    // Saturation (R8)
    doReset();
    upReady = 1'b1;
    for (int r = 0; r < 20; r++) pushReq(3, r, 64);
    tick(3);
    check("R8 unpaced forwarded", logCount, 20);
    for (int r = 0; r < 15; r++) sendCpl(3);
    check("R8 no error after max", int'(errSticky), 0);
    sendCpl(3);
    check("R8 saturated count", int'(errSticky), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule